// File: doc/BRIEF.md
# Address-Decoded Direct Message Interrupt Controller

This block accepts message-signalled interrupt writes on a simple single-beat bus port and turns each one into a pending bit for one CPU. It does not use a routing table. The bus offset is added to a base parameter to rebuild the full 40-bit message address. Two address fields are then read from that address: the interrupt vector (bits [11:4]) and the destination CPU (bits [19:12]). The data word of the write has no effect. Bits [39:28] of the rebuilt address must equal the same bits of the base, or the write is not accepted.

Each CPU has a 256-bit pending vector and one interrupt line. The interrupt line is high while any bit of that CPU's vector is set. The core side retires a vector through a per-CPU clear strobe that carries a vector index. A read of the window returns zero one cycle later and changes nothing.

Top module: `dmsi_ctrl`

## Requirements
- R1: A write (`bus_valid`=1, `bus_we`=1) sets pending bit V of the addressed CPU, where V is bus address bits [11:4]. The bit is visible after the next rising clock edge.
- R2: The destination CPU is bus address bits [19:12]. Only that CPU's pending vector and interrupt line change.
- R3: The value on `bus_wdata` has no effect on which bit is set or on any other state.
- R4: A read (`bus_valid`=1, `bus_we`=0) raises `bus_rvalid` for one cycle after the next edge, with `bus_rdata` equal to zero. It leaves every pending bit and interrupt line unchanged.
- R5: A write whose CPU field is N_CPU or above is dropped and changes no state.
- R6: `irq_o[c]` is high exactly while CPU c has at least one pending bit set. It stays high until the last such bit is cleared.
- R7: A clear strobe `clr_valid[c]` with index `clr_vec[c*8 +: 8]` clears only that one pending bit of CPU c after the next edge.
- R8: If a write sets the same bit that a clear strobe clears in the same cycle, the bit ends up set.
- R9: Synchronous reset `rst` clears every pending bit, drops every interrupt line and drops `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Single-beat request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFF_W (20) | Offset inside the window |
| bus_wdata | input | DATA_W (32) | Write payload, ignored |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | DATA_W (32) | Read data, always zero |
| clr_valid | input | N_CPU (4) | Per-CPU clear strobe |
| clr_vec | input | N_CPU*8 (32) | Per-CPU vector index to clear |
| pend_o | output | N_CPU*256 (1024) | Pending vectors, CPU c at [c*256 +: 256] |
| irq_o | output | N_CPU (4) | Per-CPU interrupt line |

## Verification
The hardest case to reach is a write and a clear that hit the same bit of the same CPU in the same cycle. Random traffic produces this only rarely, because it needs a matching CPU and a matching vector. The stimulus creates it in two ways. A directed case forces the collision. The random phase draws vectors from a small range and CPUs from a range slightly larger than N_CPU, which makes collisions, out-of-range drops and last-bit clears common. Every cycle is compared with a bench model of the pending bits.

// File: rtl/dmsi_pkg.sv
package dmsi_pkg;
  localparam int MSG_W   = 40;
  localparam int VEC_W   = 8;
  localparam int CPU_W   = 8;
  localparam int TAG_W   = 12;
  localparam int VEC_LSB = 4;
  localparam int CPU_LSB = 12;
  localparam int TAG_LSB = 28;
  localparam int NVEC    = 1 << VEC_W;

  typedef logic [MSG_W-1:0] msg_addr_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CPU_W-1:0] cpu_t;
  typedef logic [TAG_W-1:0] tag_t;

  function automatic msg_addr_t rebuild_addr(msg_addr_t base, msg_addr_t off);
    return base + off;
  endfunction

  function automatic vec_t vec_field(msg_addr_t a);
    return a[VEC_LSB +: VEC_W];
  endfunction

  function automatic cpu_t cpu_field(msg_addr_t a);
    return a[CPU_LSB +: CPU_W];
  endfunction

  function automatic tag_t tag_field(msg_addr_t a);
    return a[TAG_LSB +: TAG_W];
  endfunction

  function automatic logic [NVEC-1:0] vec_mask(vec_t v);
    return {{(NVEC-1){1'b0}}, 1'b1} << v;
  endfunction
endpackage

// File: rtl/dmsi_decode.sv
module dmsi_decode
  import dmsi_pkg::*;
#(
  parameter int        N_CPU = 4,
  parameter int        OFF_W = 20,
  parameter msg_addr_t BASE  = 40'hFE_0000_0000
) (
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [OFF_W-1:0] bus_addr,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic             wr_drop,
  output logic [N_CPU-1:0] cpu_hit,
  output vec_t             hit_vec
);
  localparam tag_t WIN_TAG = tag_field(BASE);

  msg_addr_t msg_addr;
  cpu_t      cpu_idx;
  logic      tag_ok;
  logic      cpu_ok;
  logic      unused_addr_bits;

  assign msg_addr = rebuild_addr(BASE, {{(MSG_W-OFF_W){1'b0}}, bus_addr});
  assign cpu_idx  = cpu_field(msg_addr);
  assign hit_vec  = vec_field(msg_addr);
  assign tag_ok   = (tag_field(msg_addr) == WIN_TAG);
  assign cpu_ok   = ({24'd0, cpu_idx} < 32'(N_CPU));
  assign unused_addr_bits = ^{msg_addr[TAG_LSB-1:CPU_LSB+CPU_W], msg_addr[VEC_LSB-1:0]};

  assign wr_fire = bus_valid && bus_we;
  assign rd_fire = bus_valid && !bus_we;
  assign wr_drop = wr_fire && !(tag_ok && cpu_ok);

  for (genvar c = 0; c < N_CPU; c++) begin : g_hit
    assign cpu_hit[c] = wr_fire && tag_ok && (cpu_idx == CPU_W'(c));
  end
endmodule

// File: rtl/dmsi_pend.sv
module dmsi_pend
  import dmsi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  vec_t            set_vec,
  input  logic            clr_en,
  input  vec_t            clr_vec,
  output logic [NVEC-1:0] pend_o,
  output logic            irq_o
);
  logic [NVEC-1:0] pend_q;
  logic [NVEC-1:0] set_mask;
  logic [NVEC-1:0] clr_mask;
  logic            collide;

  assign set_mask = set_en ? vec_mask(set_vec) : '0;
  assign clr_mask = clr_en ? vec_mask(clr_vec) : '0;
  assign collide  = set_en && clr_en && (set_vec == clr_vec);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  assert_set_lands_R1: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_vec)]);

  assert_clear_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !collide) |=> !pend_q[$past(clr_vec)]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    collide |=> pend_q[$past(set_vec)]);

  assert_irq_drop_cause_R6: assert property (@(posedge clk)
    $fell(irq_o) |-> ($past(clr_en) || $past(rst)));
endmodule

// File: rtl/dmsi_ctrl.sv
module dmsi_ctrl
  import dmsi_pkg::*;
#(
  parameter int        N_CPU  = 4,
  parameter int        OFF_W  = 20,
  parameter int        DATA_W = 32,
  parameter msg_addr_t BASE   = 40'hFE_0000_0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_we,
  input  logic [OFF_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic                    bus_rvalid,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N_CPU-1:0]        clr_valid,
  input  logic [N_CPU*VEC_W-1:0]  clr_vec,
  output logic [N_CPU*NVEC-1:0]   pend_o,
  output logic [N_CPU-1:0]        irq_o
);
  logic             wr_fire;
  logic             rd_fire;
  logic             wr_drop;
  logic [N_CPU-1:0] cpu_hit;
  vec_t             hit_vec;
  logic             rvalid_q;
  logic             unused_payload;

  assign unused_payload = ^bus_wdata;

  dmsi_decode #(.N_CPU(N_CPU), .OFF_W(OFF_W), .BASE(BASE)) u_decode (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .wr_drop   (wr_drop),
    .cpu_hit   (cpu_hit),
    .hit_vec   (hit_vec)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    dmsi_pend u_pend (
      .clk     (clk),
      .rst     (rst),
      .set_en  (cpu_hit[c]),
      .set_vec (hit_vec),
      .clr_en  (clr_valid[c]),
      .clr_vec (clr_vec[c*VEC_W +: VEC_W]),
      .pend_o  (pend_o[c*NVEC +: NVEC]),
      .irq_o   (irq_o[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= rd_fire;
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = '0;

  assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cpu_hit));

  assert_drop_no_target_R5: assert property (@(posedge clk) disable iff (rst)
    wr_drop |-> (cpu_hit == '0));

  assert_read_reply_R4: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> (bus_rvalid && (bus_rdata == '0)));

  assert_read_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> (cpu_hit == '0));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> ((irq_o == '0) && !bus_rvalid));
endmodule

// File: tb/test_dmsi_ctrl.sv
module test_dmsi_ctrl;
  localparam int N_CPU = 4;
  localparam int OFF_W = 20;
  localparam int NV    = 256;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 bus_valid, bus_we;
  logic [OFF_W-1:0]     bus_addr;
  logic [31:0]          bus_wdata;
  logic                 bus_rvalid;
  logic [31:0]          bus_rdata;
  logic [N_CPU-1:0]     clr_valid;
  logic [N_CPU*8-1:0]   clr_vec;
  logic [N_CPU*NV-1:0]  pend_o;
  logic [N_CPU-1:0]     irq_o;

  bit exp_pend [N_CPU][NV];
  bit exp_rvalid;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dmsi_ctrl i_dmsi_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .clr_valid(clr_valid), .clr_vec(clr_vec),
    .pend_o(pend_o), .irq_o(irq_o)
  );

  function automatic logic [OFF_W-1:0] mk_addr(int cpu, int vec);
    logic [7:0] c8 = cpu[7:0];
    logic [7:0] v8 = vec[7:0];
    return {c8, v8, 4'h0};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    clr_valid = '0; clr_vec = '0;
  endtask

  task automatic wr(int cpu, int vec, logic [31:0] data);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(cpu, vec); bus_wdata = data;
  endtask

  task automatic clr(int cpu, int vec);
    clr_valid[cpu] = 1'b1; clr_vec[cpu*8 +: 8] = vec[7:0];
  endtask

  // advance one edge, update the model from the inputs held over that edge, compare
  task automatic tick(string req);
    @(posedge clk);
    #2;
    if (rst) begin
      foreach (exp_pend[c, v]) exp_pend[c][v] = 1'b0;
      exp_rvalid = 1'b0;
    end else begin
      exp_rvalid = bus_valid && !bus_we;
      for (int c = 0; c < N_CPU; c++)
        if (clr_valid[c]) exp_pend[c][clr_vec[c*8 +: 8]] = 1'b0;
      if (bus_valid && bus_we && (int'(bus_addr[19:12]) < N_CPU))
        exp_pend[bus_addr[19:12]][bus_addr[11:4]] = 1'b1;
    end
    for (int c = 0; c < N_CPU; c++) begin
      int  bad = -1;
      bit  any = 1'b0;
      for (int v = 0; v < NV; v++) begin
        any |= exp_pend[c][v];
        if (bad < 0 && pend_o[c*NV + v] !== exp_pend[c][v]) bad = v;
      end
      chk(bad < 0, {req, " pend"}, (bad < 0) ? 64'(0) : 64'(pend_o[c*NV + bad]),
          (bad < 0) ? 64'(0) : 64'(exp_pend[c][bad]));
      chk(irq_o[c] === any, {req, " irq (R6)"}, 64'(irq_o[c]), 64'(any));
    end
    chk(bus_rvalid === exp_rvalid, {req, " rvalid (R4)"}, 64'(bus_rvalid), 64'(exp_rvalid));
    if (bus_rvalid) chk(bus_rdata === 32'd0, "R4 rdata", 64'(bus_rdata), 64'd0);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst = 1'b1;
    tick("R9 reset");
    tick("R9 reset");
    rst = 1'b0;
    tick("R9 idle");

    wr(1, 0, 32'h0); tick("R1 R2 cpu1 vec0");
    wr(3, 255, 32'h1234_5678); tick("R1 R2 cpu3 vec255");
    wr(0, 5, 32'hFFFF_FFFF); tick("R3 data ones");
    wr(0, 6, 32'h0000_0000); tick("R3 data zero");
    chk(pend_o[5] && pend_o[6] && !pend_o[7], "R3 exact bits", 64'(pend_o[7:5]), 64'b011);

    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = mk_addr(2, 17); tick("R4 read");
    tick("R4 after read");
    chk(irq_o[2] === 1'b0, "R4 read has no effect", 64'(irq_o[2]), 64'd0);

    wr(4, 9, 32'h0); tick("R5 cpu4 dropped");
    wr(255, 9, 32'h0); tick("R5 cpu255 dropped");
    chk(irq_o === 4'b1011, "R5 lines unchanged", 64'(irq_o), 64'b1011);

    clr(0, 5); tick("R7 clear one of two");
    chk(irq_o[0] === 1'b1, "R6 still pending", 64'(irq_o[0]), 64'd1);
    clr(0, 6); tick("R7 clear last");
    chk(irq_o[0] === 1'b0, "R6 line drops", 64'(irq_o[0]), 64'd0);
    clr(2, 33); tick("R7 clear of empty bit");

    wr(2, 9, 32'h0); clr(2, 9); tick("R8 set and clear collide");
    chk(pend_o[2*NV + 9] === 1'b1, "R8 set wins", 64'(pend_o[2*NV + 9]), 64'd1);
    wr(2, 10, 32'h0); clr(2, 9); tick("R8 set other bit while clearing");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) != 0) begin
        bus_valid = 1'b1;
        bus_we    = ($urandom_range(0, 5) != 0);
        bus_addr  = mk_addr($urandom_range(0, N_CPU + 1), $urandom_range(0, 15));
        bus_wdata = $urandom();
      end
      for (int c = 0; c < N_CPU; c++)
        if ($urandom_range(0, 2) == 0) clr(c, $urandom_range(0, 15));
      tick("R1 R2 R3 R5 R6 R7 R8 random");
    end

    wr(1, 200, 32'h0); tick("R1 before reset");
    rst = 1'b1; wr(2, 3, 32'h0); tick("R9 reset wins over write");
    rst = 1'b0; tick("R9 after reset");
    chk(irq_o === 4'b0000, "R9 all lines low", 64'(irq_o), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule